// File: doc/BRIEF.md
# Virtual-8086 Linear Address Generator

This block turns a segment selector and an effective address into a 32-bit linear address for a processor that runs legacy 16-bit code inside a virtual-machine mode. When the mode flag is set, descriptors are not used. The base is the selector shifted left by four bit positions. The offset is added to it with the carry kept, so a result can reach just past the first megabyte.

Offsets wider than 16 bits can be requested through the address-size indicator. A value above 65,535 is refused with a pseudo-protection fault and a vector number, and no address is produced. With the mode flag clear, the block adds a descriptor base taken from a port to the full effective address. The request is registered once, and the result or the fault appears one cycle after the request strobe.

Top module: `v86_lin_addr`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `lin_o`, `vld_o`, `flt_o` and `fvec_o` are all zero.
- R2: With `vm_i`=1 and `asz32_i`=0, a request gives `vld_o`=1 one cycle later and `lin_o` = (`sel_i` × 16) + `ea_i[15:0]`. Bits 31..21 of `lin_o` are zero.
- R3: In virtual-machine mode the carry of the add is kept as address bit 20 and is not wrapped. Selector FFFFh with offset FFFFh gives 10FFEFh.
- R4: With `vm_i`=1, `asz32_i`=1 and `ea_i` > 65535, a request gives `flt_o`=1 and `vld_o`=0 one cycle later. `fvec_o` is 12 when `stk_i`=1 and 13 otherwise.
- R5: With `vm_i`=1, `asz32_i`=1 and `ea_i` ≤ 65535, the request completes as in R2 with no fault.
- R6: With `vm_i`=1 and `asz32_i`=0, bits 31..16 of `ea_i` have no effect on `lin_o` and never raise a fault.
- R7: With `vm_i`=0, a request gives `vld_o`=1 and `lin_o` = (`dbase_i` + `ea_i`) mod 2^32. No fault is raised for any value or address size.
- R8: `vld_o` and `flt_o` are never high together. Each is high only in the cycle after a cycle with `req_i`=1, and both are low one cycle after a cycle without a request.
- R9: `lin_o` changes only when `vld_o` rises with a new address. `fvec_o` changes only when a fault is reported. Both hold their values otherwise, including through a fault and through idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, one cycle per address |
| vm_i | input | 1 | Virtual-machine mode flag |
| asz32_i | input | 1 | 1 selects 32-bit effective address, 0 selects 16-bit |
| stk_i | input | 1 | Reference goes through the stack segment |
| sel_i | input | 16 | Segment selector value |
| ea_i | input | 32 | Effective address |
| dbase_i | input | 32 | Descriptor base used when `vm_i` is 0 |
| lin_o | output | 32 | Linear address |
| vld_o | output | 1 | Linear address produced this cycle |
| flt_o | output | 1 | Pseudo-protection fault this cycle |
| fvec_o | output | 8 | Fault vector number |

## Verification
The block has one register stage, so any wrong internal value reaches the ports in the cycle right after the request that caused it. A missing carry bit shows as an address 1 MB too low at the top of the selector range. A wrong range test shows either as a fault where an address was expected, or as an address where a fault was expected. A stale or wrongly loaded hold register shows in the idle cycle after a request, or after a fault, as a changed `lin_o` or `fvec_o`. The sweeps run every selector step against boundary offsets in both modes and both address sizes, so each of these faults is seen within a few requests.

// File: rtl/v86_lin_addr.sv
module v86_lin_addr #(
  parameter int SEG_W  = 16,
  parameter int EA_W   = 32,
  parameter int LA_W   = 32,
  parameter int OFF_W  = 16,
  parameter int VEC_W  = 8,
  parameter int VEC_SS = 12,
  parameter int VEC_GP = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              vm_i,
  input  logic              asz32_i,
  input  logic              stk_i,
  input  logic [SEG_W-1:0]  sel_i,
  input  logic [EA_W-1:0]   ea_i,
  input  logic [LA_W-1:0]   dbase_i,
  output logic [LA_W-1:0]   lin_o,
  output logic              vld_o,
  output logic              flt_o,
  output logic [VEC_W-1:0]  fvec_o
);

  localparam int BASE_W = SEG_W + 4;

  logic [LA_W-1:0] vm_base, vm_off, nxt_lin;
  logic            over;

  assign vm_base = LA_W'({sel_i, 4'b0000});
  assign vm_off  = LA_W'(ea_i[OFF_W-1:0]);
  assign over    = vm_i && asz32_i && (|ea_i[EA_W-1:OFF_W]);
  assign nxt_lin = vm_i ? (vm_base + vm_off) : (dbase_i + LA_W'(ea_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lin_o  <= '0;
      vld_o  <= 1'b0;
      flt_o  <= 1'b0;
      fvec_o <= '0;
    end else begin
      vld_o <= req_i && !over;
      flt_o <= req_i && over;
      if (req_i && !over) lin_o <= nxt_lin;
      if (req_i && over)  fvec_o <= stk_i ? VEC_W'(VEC_SS) : VEC_W'(VEC_GP);
    end
  end

  AST_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(vld_o && flt_o)); // R8
  AST_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) (vld_o || flt_o) |-> $past(req_i)); // R8
  AST_VM_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (vld_o && $past(vm_i)) |-> (lin_o[LA_W-1:BASE_W+1] == '0)); // R2
  AST_FLT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) flt_o |-> $past(vm_i && asz32_i && ea_i > EA_W'(2**OFF_W - 1))); // R4
  AST_FVEC_CODE: assert property (@(posedge clk) disable iff (!rst_n) flt_o |-> (fvec_o == VEC_W'(VEC_SS) || fvec_o == VEC_W'(VEC_GP))); // R4
  AST_LIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !vld_o |-> $stable(lin_o)); // R9
  AST_FVEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !flt_o |-> $stable(fvec_o)); // R9

endmodule

// File: tb/test_v86_lin_addr.sv
`timescale 1ns/1ps
module test_v86_lin_addr;
  logic clk = 0, rst_n = 0, req = 0, vm = 0, asz = 0, stk = 0;
  logic [15:0] sel = 0;
  logic [31:0] ea = 0, db = 0;
  logic [31:0] lin;
  logic vld, flt;
  logic [7:0] fvec;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  v86_lin_addr i_v86_lin_addr (
    .clk(clk), .rst_n(rst_n), .req_i(req), .vm_i(vm), .asz32_i(asz), .stk_i(stk),
    .sel_i(sel), .ea_i(ea), .dbase_i(db), .lin_o(lin), .vld_o(vld), .flt_o(flt), .fvec_o(fvec));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  logic [31:0] last_lin = 0;
  logic [7:0]  last_vec = 0;

  task automatic op(input bit m, input bit a, input bit s, input logic [15:0] sv,
                    input logic [31:0] e, input logic [31:0] b, input string r);
    logic [31:0] exp;
    bit fault;
    @(negedge clk);
    vm = m; asz = a; stk = s; sel = sv; ea = e; db = b; req = 1;
    fault = m && a && (e > 32'd65535);
    if (m) exp = {12'd0, sv, 4'd0} + {16'd0, e[15:0]};
    else   exp = b + e;
    @(negedge clk);
    req = 0;
    chk({r, " vld"}, {31'd0, vld}, {31'd0, !fault});
    chk({r, " flt"}, {31'd0, flt}, {31'd0, fault});
    if (fault) begin
      last_vec = s ? 8'd12 : 8'd13;
      chk({r, " fvec"}, {24'd0, fvec}, {24'd0, last_vec});
      chk("R9 lin held through fault", lin, last_lin);
    end else begin
      last_lin = exp;
      chk(r, lin, exp);
      if (m) chk("R2 high bits zero", {21'd0, lin[31:21]}, 32'd0);
    end
    @(negedge clk);
    chk("R8 idle vld", {31'd0, vld}, 32'd0);
    chk("R8 idle flt", {31'd0, flt}, 32'd0);
    chk("R9 idle lin hold", lin, last_lin);
    chk("R9 idle fvec hold", {24'd0, fvec}, {24'd0, last_vec});
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] offs [8];
    offs = '{32'h0, 32'h1, 32'h7FFF, 32'h8000, 32'hFFF0, 32'hFFFE, 32'hFFFF, 32'h1234};
    repeat (3) @(negedge clk);
    chk("R1 reset lin", lin, 0);
    chk("R1 reset vld", {31'd0, vld}, 0);
    chk("R1 reset flt", {31'd0, flt}, 0);
    chk("R1 reset fvec", {24'd0, fvec}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset vld", {31'd0, vld}, 0);
    chk("R1 after reset lin", lin, 0);

    for (int s = 0; s < 17; s++) begin
      logic [15:0] sv;
      sv = (s == 16) ? 16'hFFFF : 16'(s * 16'h1001);
      for (int k = 0; k < 8; k++) begin
        op(1, 0, 0, sv, offs[k], 32'h0, "R2 vm 16-bit");
        op(1, 1, 0, sv, offs[k], 32'h0, "R5 vm 32-bit in range");
        op(1, 0, k[0], sv, offs[k] | 32'hABCD_0000, 32'h0, "R6 upper ea ignored");
      end
    end
    op(1, 0, 0, 16'hFFFF, 32'hFFFF, 0, "R3 max address");
    chk("R3 max value", lin, 32'h0010FFEF);
    op(1, 0, 0, 16'hF001, 32'hFFFF, 0, "R3 carry into bit 20");

    op(1, 1, 1, 16'h1234, 32'h0001_0000, 0, "R4 stack fault");
    op(1, 1, 0, 16'h1234, 32'h0001_0000, 0, "R4 general fault");
    op(1, 1, 0, 16'h0000, 32'hFFFF_FFFF, 0, "R4 general fault max");
    op(1, 1, 1, 16'hFFFF, 32'h8000_0000, 0, "R4 stack fault msb");
    op(1, 1, 0, 16'h0010, 32'h0000_FFFF, 0, "R5 boundary 65535");

    for (int k = 0; k < 32; k++) begin
      logic [31:0] b, e;
      b = 32'h1000_0000 * (k % 16) + 32'h0003_0F07 * k;
      e = (k == 31) ? 32'hFFFF_FFFF : 32'h0101_0101 * k;
      op(0, k[0], k[1], 16'(k * 777), e, b, "R7 descriptor base");
    end
    op(0, 0, 0, 0, 32'hFFFF_FFFF, 32'h0000_0002, "R7 wraps");
    chk("R7 wrap value", lin, 32'h1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule